// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block receives 8-bit bytes over a two-wire synchronous link made of a serial clock and a data line. The serial clock has two possible sources. In internal mode the block makes the clock itself from the system clock and drives it out. In external mode a remote master supplies the clock, and the block synchronises it and watches for its rising edges. Bits arrive least significant first. Each bit is taken on a rising edge of the serial clock. After eight bits, the byte moves from the shift register into a holding buffer that the host can read, and a one-cycle buffer-full interrupt pulse is raised.

The host drives three controls. A start level begins reception on its rising edge. Taking that level low ends reception gracefully, at the next byte boundary. An abort pulse stops reception at once and throws away the partial byte. The host reads the buffer with a one-cycle read strobe and can poll a busy flag.

Flow control depends on the clock source. In internal mode the clock is parked high at the byte boundary until the host has read the buffer. In external mode the block cannot hold the clock, so a byte that completes while the buffer is still unread is dropped and an overrun flag is raised.

Top module: `clksync_rx`

## Requirements
- R1: Bits are sampled on rising serial clock edges and assembled least significant bit first. After the eighth bit, `rd_data` shows the byte, with the first bit received in bit 0.
- R2: Every byte written into the buffer raises `full_irq` for exactly one system clock cycle. A byte that is not stored raises no pulse.
- R3: In internal mode (`ext_mode`=0), `sck_oe` is 1. The serial clock idles high, and its period is 8 << `div_sel` system clock cycles. In external mode `sck_oe` is 0.
- R4: In internal mode, while the buffer holds an unread byte at a byte boundary, `sck_out` stays high and `busy` stays 1. After a read, reception resumes and the next byte is received intact.
- R5: In external mode, a byte that completes while the buffer is unread is discarded. `rd_data` keeps the old byte, no interrupt is raised, and `overrun` becomes 1.
- R6: A read strobe (`rd_en`=1 for one cycle) clears `overrun` and frees the buffer for the next byte.
- R7: A 0-to-1 transition of `start` while idle sets `busy` to 1 and starts reception.
- R8: Taking `start` to 0 in the middle of a byte lets that byte finish and be stored. `busy` then falls to 0, and no further bytes are taken.
- R9: An `abort` pulse clears `busy` on the next cycle. The partial byte is neither stored nor signalled. A later start receives the next byte from its first bit.
- R10: Any change of `ext_mode` clears `rd_data` to 0, clears `overrun` and ends reception.
- R11: External clock edges that arrive while the block is idle are ignored, so the first byte after start lines up on its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mode | input | 1 | Clock source: 0 internal divider, 1 external master |
| div_sel | input | 3 | Internal divide select, period = 8 << div_sel |
| start | input | 1 | Run level: rising edge starts, low requests graceful stop |
| abort | input | 1 | Immediate stop, partial byte discarded |
| rd_en | input | 1 | One-cycle buffer read strobe |
| sck_in | input | 1 | Serial clock from an external master |
| sdi | input | 1 | Serial data input |
| sck_out | output | 1 | Generated serial clock, idles high |
| sck_oe | output | 1 | Drive enable for sck_out (internal mode) |
| rd_data | output | 8 | Receive buffer contents |
| full_irq | output | 1 | Buffer-full interrupt pulse |
| busy | output | 1 | Reception active |
| overrun | output | 1 | External-mode byte dropped since the last read |

## Verification
A wrong bit counter or shift direction shows up on `rd_data` as a rotated or bit-reversed byte. This is visible about six system cycles after the eighth rising serial edge. The full internal sweep of all 256 byte values exposes it on the first asymmetric value.

A stall condition that is wrong either lets `sck_out` fall while the buffer is unread, which is caught within one serial half period, or parks the clock forever, which stops the next byte. A broken overrun path either overwrites `rd_data` or drops the interrupt count, and this is visible a few cycles after the second unread byte. Errors in abort and mode-change handling show as `busy` still high one cycle later, or as an old byte remaining on `rd_data`.

// File: rtl/clksync_rx_pkg.sv
package clksync_rx_pkg;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned DIVSEL_W     = 3;
  localparam int unsigned MIN_DIV_LOG2 = 3;

  typedef enum logic {SRC_INTERNAL = 1'b0, SRC_EXTERNAL = 1'b1} clk_src_e;

  // number of system cycles in half a serial clock period
  function automatic int unsigned half_period(input int unsigned sel);
    return 32'd1 << (MIN_DIV_LOG2 - 1 + sel);
  endfunction
endpackage

// File: rtl/clksync_rx_clkgen.sv
module clksync_rx_clkgen
  import clksync_rx_pkg::*;
#(
  parameter int unsigned SEL_W = DIVSEL_W,
  parameter int unsigned CNT_W = MIN_DIV_LOG2 + (1 << SEL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             sck_in,
  input  logic             sdi,
  output logic             sck_out,
  output logic             bit_stb,
  output logic             bit_val
);
  logic [CNT_W-1:0] cnt;
  logic             sck_q;
  logic [2:0]       sck_sync;
  logic [1:0]       sdi_sync;

  logic half_done, int_rise, ext_rise;
  assign half_done = (cnt == CNT_W'(half_period({{(32-SEL_W){1'b0}}, div_sel}) - 1));
  assign int_rise  = run && !ext_mode && half_done && !sck_q;
  assign ext_rise  = ext_mode && sck_sync[1] && !sck_sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sck_q    <= 1'b1;
      sck_sync <= 3'b111;
      sdi_sync <= 2'b00;
      bit_stb  <= 1'b0;
      bit_val  <= 1'b0;
    end else begin
      sck_sync <= {sck_sync[1:0], sck_in};
      sdi_sync <= {sdi_sync[0], sdi};
      if (!run || ext_mode) begin
        cnt   <= '0;
        sck_q <= 1'b1;
      end else if (half_done) begin
        cnt   <= '0;
        sck_q <= !sck_q;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
      bit_stb <= int_rise || ext_rise;
      bit_val <= ext_mode ? sdi_sync[1] : sdi;
    end
  end

  assign sck_out = sck_q;

  // R3: a stopped or external-mode generator parks the clock high
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || ext_mode) |=> sck_out);
  // R3: in internal mode the clock may only change after a full half period
  p_half_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ext_mode && !half_done) |=> $stable(sck_out));
endmodule

// File: rtl/clksync_rx_shifter.sv
module clksync_rx_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         stb,
  input  logic         bit_val,
  output logic         byte_done,
  output logic [W-1:0] byte_data,
  output logic         at_boundary
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;
  logic          last;

  assign last        = (cnt == CW'(W - 1));
  assign byte_data   = {bit_val, sr[W-1:1]};
  assign byte_done   = stb && last && !clr;
  assign at_boundary = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clr) begin
      sr  <= '0;
      cnt <= '0;
    end else if (stb) begin
      sr  <= byte_data;
      cnt <= last ? '0 : cnt + CW'(1);
    end
  end

  // R9: a clear always restarts on the first bit of a byte
  p_clear_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> at_boundary);
endmodule

// File: rtl/clksync_rx.sv
module clksync_rx
  import clksync_rx_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  parameter int unsigned SEL_W  = DIVSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic              start,
  input  logic              abort,
  input  logic              rd_en,
  input  logic              sck_in,
  input  logic              sdi,
  output logic              sck_out,
  output logic              sck_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              full_irq,
  output logic              busy,
  output logic              overrun
);
  localparam int unsigned CNT_W = MIN_DIV_LOG2 + (1 << SEL_W);

  logic              mode_q, start_q, busy_q, buf_valid, ovr_q, irq_q;
  logic [DATA_W-1:0] buf_q;
  logic              stb, bval, byte_done, at_bnd;
  logic [DATA_W-1:0] byte_data;

  // named internal events
  logic mode_chg, kill, start_rise, stall, run, accept, store, drop, stop_done;
  assign mode_chg   = (ext_mode != mode_q);
  assign kill       = abort || mode_chg;
  assign start_rise = start && !start_q;
  assign stall      = at_bnd && (buf_valid || !start);
  assign run        = busy_q && !stall && !kill;
  assign accept     = byte_done && busy_q;
  assign store      = accept && (!buf_valid || rd_en);
  assign drop       = accept && buf_valid && !rd_en;
  assign stop_done  = busy_q && at_bnd && !start;

  clksync_rx_clkgen #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .run(run),
    .div_sel(div_sel), .sck_in(sck_in), .sdi(sdi),
    .sck_out(sck_out), .bit_stb(stb), .bit_val(bval)
  );

  clksync_rx_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(!busy_q || kill), .stb(stb && busy_q),
    .bit_val(bval), .byte_done(byte_done), .byte_data(byte_data),
    .at_boundary(at_bnd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= SRC_INTERNAL;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      mode_q  <= ext_mode;
      start_q <= start;
      if (kill)                    busy_q <= 1'b0;
      else if (!busy_q && start_rise) busy_q <= 1'b1;
      else if (stop_done)          busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q     <= '0;
      buf_valid <= 1'b0;
      ovr_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else if (mode_chg) begin
      buf_q     <= '0;
      buf_valid <= 1'b0;
      ovr_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= store;
      if (rd_en) begin
        buf_valid <= 1'b0;
        ovr_q     <= 1'b0;
      end
      if (store) begin
        buf_q     <= byte_data;
        buf_valid <= 1'b1;
      end
      if (drop) ovr_q <= 1'b1;
    end
  end

  assign sck_oe   = (ext_mode == SRC_INTERNAL);
  assign rd_data  = buf_q;
  assign full_irq = irq_q;
  assign busy     = busy_q;
  assign overrun  = ovr_q;

  p_irq_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full_irq |=> !full_irq);
  p_irq_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full_irq |-> buf_valid);
  p_hold_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && busy_q && at_bnd && buf_valid) |-> sck_out);
  p_no_int_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> ext_mode);
  p_drop_keeps_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !mode_chg) |=> ($stable(rd_data) && overrun));
  p_abort_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);
  p_mode_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (rd_data == '0 && !overrun && !busy));
endmodule

// File: tb/clksync_rx_test.sv
module clksync_rx_test;
  logic       clk = 1'b0;
  logic       rst_n, ext_mode, start, abort, rd_en, sck_in, sdi;
  logic [2:0] div_sel;
  logic       sck_out, sck_oe, full_irq, busy, overrun;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int irq_cnt = 0;
  int long_irq = 0;
  int exp_irq = 0;
  logic irq_prev = 1'b0;

  always #4 clk = !clk;

  clksync_rx uut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .div_sel(div_sel),
    .start(start), .abort(abort), .rd_en(rd_en), .sck_in(sck_in), .sdi(sdi),
    .sck_out(sck_out), .sck_oe(sck_oe), .rd_data(rd_data),
    .full_irq(full_irq), .busy(busy), .overrun(overrun)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (full_irq === 1'b1) begin
      irq_cnt = irq_cnt + 1;
      if (irq_prev === 1'b1) long_irq = long_irq + 1;
    end
    irq_prev = full_irq;
    if (cyc == 150000) begin
      $display("FAIL watchdog: run did not finish, actual cyc=%0d expected <150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    start = 1'b0; @(negedge clk);
    start = 1'b1; @(negedge clk);
  endtask

  task automatic do_read();
    rd_en = 1'b1; @(negedge clk);
    rd_en = 1'b0; @(negedge clk);
  endtask

  task automatic wait_fall();
    while (sck_out !== 1'b1) @(negedge clk);
    while (sck_out !== 1'b0) @(negedge clk);
  endtask

  task automatic int_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      wait_fall();
      sdi = b[i];
    end
    while (sck_out !== 1'b1) @(negedge clk);
  endtask

  task automatic ext_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sck_in = 1'b0; sdi = b[i];
      repeat (5) @(negedge clk);
      sck_in = 1'b1;
      repeat (5) @(negedge clk);
    end
  endtask

  task automatic expect_byte(input logic [7:0] v, input string req);
    exp_irq = exp_irq + 1;
    chk(irq_cnt == exp_irq, "R2 irq count", irq_cnt, exp_irq);
    chk(rd_data == v, req, rd_data, v);
  endtask

  initial begin
    int t1, t2, lows;
    rst_n = 1'b0; ext_mode = 1'b0; div_sel = 3'd0; start = 1'b0;
    abort = 1'b0; rd_en = 1'b0; sck_in = 1'b1; sdi = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk(rd_data == 8'h00, "reset rd_data", rd_data, 0);
    chk(busy == 1'b0, "reset busy", busy, 0);
    chk(full_irq == 1'b0 && overrun == 1'b0, "reset flags", {full_irq, overrun}, 0);
    chk(sck_out == 1'b1 && sck_oe == 1'b1, "R3 idle clock", {sck_out, sck_oe}, 3);

    // R3 divider period sweep, each run ended by abort (R9)
    for (int sel = 0; sel < 4; sel++) begin
      div_sel = 3'(sel);
      do_start();
      wait_fall(); t1 = cyc;
      wait_fall(); t2 = cyc;
      chk((t2 - t1) == (8 << sel), "R3 period", t2 - t1, 8 << sel);
      abort = 1'b1; @(negedge clk); abort = 1'b0;
      chk(busy == 1'b0, "R9 abort clears busy", busy, 0);
      repeat (3) @(negedge clk);
    end
    chk(irq_cnt == 0, "R9 no irq after aborts", irq_cnt, 0);

    // R1/R2/R7 exhaustive internal sweep
    div_sel = 3'd0;
    do_start();
    chk(busy == 1'b1, "R7 start sets busy", busy, 1);
    for (int v = 0; v < 256; v++) begin
      int_bits(8'(v), 8);
      repeat (6) @(negedge clk);
      expect_byte(8'(v), "R1 internal byte");
      do_read();
    end

    // R4 clock held while unread
    int_bits(8'h3C, 8);
    repeat (6) @(negedge clk);
    expect_byte(8'h3C, "R4 first byte");
    lows = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sck_out !== 1'b1) lows++;
    end
    chk(lows == 0, "R4 clock parked", lows, 0);
    chk(busy == 1'b1, "R4 busy while parked", busy, 1);
    do_read();
    int_bits(8'hC3, 8);
    repeat (6) @(negedge clk);
    expect_byte(8'hC3, "R4 resume byte");
    do_read();

    // R8 graceful stop, internal
    int_bits(8'h5A, 4);
    start = 1'b0;
    int_bits(8'h05, 4);
    repeat (6) @(negedge clk);
    expect_byte(8'h5A, "R8 internal finish byte");
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R8 busy falls", busy, 0);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sck_out !== 1'b1) lows++;
    end
    chk(lows == 0, "R8 no clocks after stop", lows, 0);
    do_read();

    // R9 abort mid-byte
    do_start();
    int_bits(8'hFF, 3);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk(busy == 1'b0, "R9 busy after abort", busy, 0);
    repeat (40) @(negedge clk);
    chk(irq_cnt == exp_irq, "R9 no irq for partial", irq_cnt, exp_irq);
    chk(rd_data == 8'h5A, "R9 buffer untouched", rd_data, 8'h5A);
    do_start();
    int_bits(8'h81, 8);
    repeat (6) @(negedge clk);
    expect_byte(8'h81, "R9 restart aligned");

    // R10 mode change clears buffer
    ext_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk(rd_data == 8'h00, "R10 buffer cleared", rd_data, 0);
    chk(busy == 1'b0 && sck_oe == 1'b0, "R10/R3 ext mode idle", {busy, sck_oe}, 0);

    // R11 idle edges ignored
    ext_bits(8'hFF, 3);
    chk(irq_cnt == exp_irq, "R11 idle edges no irq", irq_cnt, exp_irq);
    do_start();
    ext_bits(8'hA5, 8);
    repeat (8) @(negedge clk);
    expect_byte(8'hA5, "R11 aligned byte");
    do_read();

    // R1 external sweep
    for (int k = 0; k < 32; k++) begin
      ext_bits(8'(k * 37 + 11), 8);
      repeat (8) @(negedge clk);
      expect_byte(8'(k * 37 + 11), "R1 external byte");
      do_read();
    end

    // R5 / R6 overrun
    ext_bits(8'h6E, 8);
    repeat (8) @(negedge clk);
    expect_byte(8'h6E, "R5 first byte");
    ext_bits(8'h91, 8);
    repeat (8) @(negedge clk);
    chk(irq_cnt == exp_irq, "R5 no irq on drop", irq_cnt, exp_irq);
    chk(rd_data == 8'h6E, "R5 old byte kept", rd_data, 8'h6E);
    chk(overrun == 1'b1, "R5 overrun set", overrun, 1);
    do_read();
    chk(overrun == 1'b0, "R6 read clears overrun", overrun, 0);
    ext_bits(8'h17, 8);
    repeat (8) @(negedge clk);
    expect_byte(8'h17, "R6 byte after read");
    do_read();

    // R8 graceful stop, external
    ext_bits(8'hB4, 5);
    start = 1'b0;
    ext_bits(8'h05, 3);
    repeat (8) @(negedge clk);
    expect_byte(8'hB4, "R8 external finish byte");
    chk(busy == 1'b0, "R8 external busy falls", busy, 0);
    do_read();
    ext_bits(8'hFF, 8);
    repeat (8) @(negedge clk);
    chk(irq_cnt == exp_irq, "R8 no bytes after stop", irq_cnt, exp_irq);

    // R10 mode change clears overrun
    do_start();
    ext_bits(8'h01, 8);
    repeat (8) @(negedge clk);
    expect_byte(8'h01, "R10 setup byte");
    ext_bits(8'h02, 8);
    repeat (8) @(negedge clk);
    chk(overrun == 1'b1, "R10 setup overrun", overrun, 1);
    ext_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(overrun == 1'b0, "R10 overrun cleared", overrun, 0);
    chk(rd_data == 8'h00, "R10 buffer cleared again", rd_data, 0);
    chk(sck_oe == 1'b1, "R3 internal drives clock", sck_oe, 1);

    chk(long_irq == 0, "R2 irq single cycle", long_irq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule